// File: doc/BRIEF.md
# UART Receive Queue with Fill-Level Trigger

This block is the receive character queue of a UART core. The serial receiver pushes each received character together with its three error flags: parity, framing and break. A host pops the characters in arrival order through a read strobe. A single 8-bit control write port configures the queue. The host does not store any of the clear bits; writing a 1 to one of them gives a one-cycle clear. The same write can also switch the capacity between a shallow and a deep setting, pick one of four fill thresholds for the data-available interrupt, and choose how the receive-ready DMA pin behaves.

When the queue is full, further characters are discarded and a sticky overrun flag is raised. A line-status read clears that flag. A transmit-ready output follows a transmit-empty input from the transmit path. A one-cycle transmit-clear pulse tells that path to empty its own queue. The pulse fires when the host asks for a transmit clear or when the capacity changes.

Control byte layout: bit 1 clears the receive queue, bit 2 requests a transmit clear, bit 3 selects the DMA mode, bit 5 selects the deep capacity, and bits 7:6 select the trigger. Bits 0 and 4 have no function.

Top module: `rxq_fifo_ctl`

## Requirements
- R1: Each accepted character is returned with its error flags, in arrival order. After a read strobe on a non-empty queue, `rd_valid` is high for one cycle in the next cycle, with the oldest entry on `rd_char` and `rd_err`.
- R2: A control write with bit 1 set leaves `count` at 0 in the next cycle. The bit is not stored: a later write with bit 1 clear does not empty the queue.
- R3: A control write with bit 1 clear and bit 5 unchanged keeps every stored character, even when the trigger or DMA fields change.
- R4: Bit 5 set gives a capacity of 64 entries; bit 5 clear gives 16. A write that changes bit 5 empties the receive queue and raises `tx_clr` for one cycle.
- R5: The threshold for trigger values 0 to 3 is 1, 4, 8 or 14 in the 16-entry setting, and 1, 16, 32 or 56 in the 64-entry setting. `data_irq` is high exactly when `count` is at or above the threshold.
- R6: A character that arrives while the queue is full and no read happens is dropped, and `overrun` is set. `lsr_rd` clears `overrun`, except that a drop in the same cycle keeps it set.
- R7: A character that arrives while the queue is full, in the same cycle as a read, is accepted. `count` stays at the capacity.
- R8: With bit 3 clear (mode 0), `rx_ready` is high whenever `count` is non-zero.
- R9: With bit 3 set (mode 1), `rx_ready` rises when `count` reaches the threshold and falls when `count` is 0. In between, it keeps its previous value.
- R10: `tx_ready` equals `tx_empty` one cycle later. A control write with bit 2 set raises `tx_clr` for one cycle.
- R11: After reset, `count`, `data_irq`, `rx_ready`, `overrun`, `rd_valid`, `tx_ready` and `tx_clr` are 0. The queue is in 16-entry mode with trigger 0 and DMA mode 0.
- R12: A read strobe on an empty queue produces no `rd_valid`. A receive clear takes priority over a read or a character in the same cycle, and both are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | CHAR_W | Received character |
| rx_err | input | ERR_W | Error flags of the received character |
| rd_en | input | 1 | Host read strobe |
| rd_char | output | CHAR_W | Character popped by the last read |
| rd_err | output | ERR_W | Error flags popped by the last read |
| rd_valid | output | 1 | Read data valid, one cycle |
| lsr_rd | input | 1 | Line status read, clears overrun |
| overrun | output | 1 | Sticky character-lost flag |
| count | output | CW | Stored character count |
| data_irq | output | 1 | Fill level at or above threshold |
| tx_empty | input | 1 | Transmit path empty |
| rx_ready | output | 1 | Receive DMA ready |
| tx_ready | output | 1 | Transmit DMA ready |
| tx_clr | output | 1 | Transmit queue clear pulse |

## Verification
Two functions collide when the queue is full: a new character and a host read can land in the same cycle. In that case the character must be accepted and `count` must hold at the capacity, with no overrun. The same holds for a drop that coincides with a line-status read, where the set must win. The bench reaches the collisions by filling the queue to capacity in both depth settings, then raising `rx_valid` together with `rd_en` or `lsr_rd`, both in directed steps and in long random bursts with a high arrival rate. A queue model in the bench judges every cycle: it checks the popped word, `count`, `overrun` and the ready outputs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // control byte field positions (a host driver decodes these)
  localparam int CTL_CLR_RX  = 1;
  localparam int CTL_CLR_TX  = 2;
  localparam int CTL_DMA     = 3;
  localparam int CTL_DEEP    = 5;
  localparam int CTL_TRIG_LO = 6;

  typedef enum logic {
    DMA_LEVEL = 1'b0,
    DMA_BURST = 1'b1
  } rxq_dma_e;

  // threshold derived from capacity: 1, 1/4, 1/2, 7/8
  function automatic int unsigned rxq_thr(input int unsigned depth, input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  output logic       deep_q,
  output rxq_dma_e   dma_q,
  output logic [1:0] trig_q,
  output logic       deep_nxt,
  output rxq_dma_e   dma_nxt,
  output logic [1:0] trig_nxt,
  output logic       flush_rx,
  output logic       flush_tx
);
  logic depth_chg;
  logic unused_bits;

  assign unused_bits = ^{ctl_data[0], ctl_data[4]};

  always_comb begin
    depth_chg = ctl_wr && (ctl_data[CTL_DEEP] != deep_q);
    deep_nxt  = ctl_wr ? ctl_data[CTL_DEEP] : deep_q;
    dma_nxt   = ctl_wr ? rxq_dma_e'(ctl_data[CTL_DMA]) : dma_q;
    trig_nxt  = ctl_wr ? ctl_data[CTL_TRIG_LO +: 2] : trig_q;
    flush_rx  = (ctl_wr && ctl_data[CTL_CLR_RX]) || depth_chg;
    flush_tx  = (ctl_wr && ctl_data[CTL_CLR_TX]) || depth_chg;
  end

  // clear bits are never stored: they act only in the write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      deep_q <= 1'b0;
      dma_q  <= DMA_LEVEL;
      trig_q <= 2'd0;
    end else begin
      deep_q <= deep_nxt;
      dma_q  <= dma_nxt;
      trig_q <= trig_nxt;
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int AW = 6,
  parameter int DW = 11,
  localparam int NWORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NWORDS];

  // plain write plus registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_track.sv
module rxq_track
  import rxq_pkg::*;
#(
  parameter int SHALLOW = 16,
  parameter int DEEP    = 64,
  localparam int AW = $clog2(DEEP),
  localparam int CW = $clog2(DEEP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rd_en,
  input  logic          lsr_rd,
  input  logic          flush,
  input  logic          deep_q,
  input  logic          deep_nxt,
  input  rxq_dma_e      dma_nxt,
  input  logic [1:0]    trig_nxt,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count_q,
  output logic          irq_q,
  output logic          ready_q,
  output logic          overrun_q,
  output logic          rd_valid_q
);
  logic [CW-1:0] cap;
  logic [AW-1:0] mask;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_nxt;
  logic [AW-1:0] wptr_nxt, rptr_nxt;
  logic          full, drop;
  logic          ready_nxt;

  always_comb begin
    cap   = deep_q ? CW'(DEEP) : CW'(SHALLOW);
    mask  = deep_q ? AW'(DEEP - 1) : AW'(SHALLOW - 1);
    thr   = CW'(rxq_thr(deep_nxt ? DEEP : SHALLOW, trig_nxt));
    full  = (count_q == cap);
    pop   = rd_en && (count_q != '0) && !flush;
    push  = rx_valid && !flush && (!full || pop);
    drop  = rx_valid && !flush && full && !pop;

    if (flush) begin
      cnt_nxt  = '0;
      wptr_nxt = '0;
      rptr_nxt = '0;
    end else begin
      cnt_nxt  = count_q + CW'(push) - CW'(pop);
      wptr_nxt = push ? ((waddr + AW'(1)) & mask) : waddr;
      rptr_nxt = pop  ? ((raddr + AW'(1)) & mask) : raddr;
    end

    if (dma_nxt == DMA_LEVEL)  ready_nxt = (cnt_nxt != '0);
    else if (cnt_nxt >= thr)   ready_nxt = 1'b1;
    else if (cnt_nxt == '0)    ready_nxt = 1'b0;
    else                       ready_nxt = ready_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      waddr      <= '0;
      raddr      <= '0;
      irq_q      <= 1'b0;
      ready_q    <= 1'b0;
      overrun_q  <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      count_q    <= cnt_nxt;
      waddr      <= wptr_nxt;
      raddr      <= rptr_nxt;
      irq_q      <= (cnt_nxt >= thr);
      ready_q    <= ready_nxt;
      rd_valid_q <= pop;
      if (drop)        overrun_q <= 1'b1;
      else if (lsr_rd) overrun_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_fifo_ctl.sv
module rxq_fifo_ctl
  import rxq_pkg::*;
#(
  parameter int SHALLOW = 16,
  parameter int DEEP    = 64,
  parameter int CHAR_W  = 8,
  parameter int ERR_W   = 3,
  localparam int CW = $clog2(DEEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_char,
  output logic [ERR_W-1:0]  rd_err,
  output logic              rd_valid,
  input  logic              lsr_rd,
  output logic              overrun,
  output logic [CW-1:0]     count,
  output logic              data_irq,
  input  logic              tx_empty,
  output logic              rx_ready,
  output logic              tx_ready,
  output logic              tx_clr
);
  localparam int AW = $clog2(DEEP);
  localparam int DW = CHAR_W + ERR_W;

  logic          deep_q, deep_nxt;
  rxq_dma_e      dma_q, dma_nxt;
  logic [1:0]    trig_q, trig_nxt;
  logic          flush_rx, flush_tx;
  logic          push, pop;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rdata;
  logic          unused_trig;

  assign unused_trig = ^trig_q;

  rxq_ctl ctl_i (
    .clk, .rst, .ctl_wr, .ctl_data,
    .deep_q, .dma_q, .trig_q,
    .deep_nxt, .dma_nxt, .trig_nxt,
    .flush_rx, .flush_tx
  );

  rxq_track #(.SHALLOW(SHALLOW), .DEEP(DEEP)) trk_i (
    .clk, .rst, .rx_valid, .rd_en, .lsr_rd,
    .flush(flush_rx), .deep_q, .deep_nxt, .dma_nxt, .trig_nxt,
    .push, .pop, .waddr, .raddr,
    .count_q(count), .irq_q(data_irq), .ready_q(rx_ready),
    .overrun_q(overrun), .rd_valid_q(rd_valid)
  );

  rxq_store #(.AW(AW), .DW(DW)) mem_i (
    .clk, .we(push), .waddr, .wdata({rx_err, rx_char}),
    .re(pop), .raddr, .rdata
  );

  assign {rd_err, rd_char} = rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ready <= 1'b0;
      tx_clr   <= 1'b0;
    end else begin
      tx_ready <= tx_empty;
      tx_clr   <= flush_tx;
    end
  end
endmodule

// File: rtl/rxq_fifo_ctl_chk.sv
module rxq_fifo_ctl_chk #(
  parameter int SHALLOW = 16,
  parameter int DEEP    = 64,
  parameter int CW      = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic          rx_valid,
  input logic          rd_en,
  input logic          lsr_rd,
  input logic          tx_empty,
  input logic [CW-1:0] count,
  input logic          data_irq,
  input logic          rx_ready,
  input logic          overrun,
  input logic          rd_valid,
  input logic          tx_ready,
  input logic          tx_clr,
  input logic          deep_q,
  input logic          dma_q
);
  logic unused_in;
  assign unused_in = rd_en;

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= (deep_q ? CW'(DEEP) : CW'(SHALLOW)));

  a_r2_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[1]) |=> (count == '0));

  a_r4_depth_switch: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (ctl_data[5] != deep_q)) |=> (tx_clr && count == '0));

  a_r5_irq_nonempty: assert property (@(posedge clk) disable iff (rst)
    data_irq |-> (count != '0));

  a_r8_mode0_ready: assert property (@(posedge clk) disable iff (rst)
    !dma_q |-> (rx_ready == (count != '0)));

  a_r9_ready_empty: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !rx_ready);

  a_r6_overrun_clear: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !rx_valid) |=> !overrun);

  a_r12_empty_read: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> !rd_valid);

  a_r10_tx_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_ready == $past(tx_empty)));
endmodule

bind rxq_fifo_ctl rxq_fifo_ctl_chk #(.SHALLOW(SHALLOW), .DEEP(DEEP), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .rx_valid(rx_valid), .rd_en(rd_en), .lsr_rd(lsr_rd), .tx_empty(tx_empty),
  .count(count), .data_irq(data_irq), .rx_ready(rx_ready), .overrun(overrun),
  .rd_valid(rd_valid), .tx_ready(tx_ready), .tx_clr(tx_clr),
  .deep_q(deep_q), .dma_q(dma_q)
);

// File: tb/rxq_fifo_ctl_tb_top.sv
`timescale 1ns/1ps
module rxq_fifo_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0;
  logic [7:0]  ctl_data = 0;
  logic        rx_valid = 0;
  logic [7:0]  rx_char = 0;
  logic [2:0]  rx_err = 0;
  logic        rd_en = 0;
  logic [7:0]  rd_char;
  logic [2:0]  rd_err;
  logic        rd_valid;
  logic        lsr_rd = 0;
  logic        overrun;
  logic [6:0]  count;
  logic        data_irq;
  logic        tx_empty = 0;
  logic        rx_ready;
  logic        tx_ready;
  logic        tx_clr;

  always #5 clk = ~clk;

  rxq_fifo_ctl dut_i (
    .clk, .rst, .ctl_wr, .ctl_data, .rx_valid, .rx_char, .rx_err,
    .rd_en, .rd_char, .rd_err, .rd_valid, .lsr_rd, .overrun, .count,
    .data_irq, .tx_empty, .rx_ready, .tx_ready, .tx_clr
  );

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [10:0] mq [$];
  bit          m_deep, m_dma, m_ov, m_ready;
  bit [1:0]    m_trig;
  bit          e_irq, e_rdv, e_txr, e_txclr;
  logic [10:0] e_word;

  function automatic int thr_of(bit deep, bit [1:0] t);
    int lv_s [4] = '{1, 4, 8, 14};
    int lv_d [4] = '{1, 16, 32, 56};
    return deep ? lv_d[t] : lv_s[t];
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    cmp("R4/R1 count", int'(count), mq.size());
    cmp("R5 data_irq", int'(data_irq), int'(e_irq));
    cmp(m_dma ? "R9 rx_ready mode1" : "R8 rx_ready mode0", int'(rx_ready), int'(m_ready));
    cmp("R6 overrun", int'(overrun), int'(m_ov));
    cmp("R12 rd_valid", int'(rd_valid), int'(e_rdv));
    if (e_rdv) cmp("R1 read word", int'({rd_err, rd_char}), int'(e_word));
    cmp("R10 tx_ready", int'(tx_ready), int'(e_txr));
    cmp("R10 tx_clr", int'(tx_clr), int'(e_txclr));
  endtask

  // one cycle: check the previous step, drive new inputs, advance the model
  task automatic step(bit w, bit [7:0] cd, bit rv, bit [10:0] word, bit re, bit lr, bit te);
    int  cap;
    bit  dchg, frx, ftx, pop, push, drop;
    @(negedge clk);
    check_outputs();
    ctl_wr = w; ctl_data = cd; rx_valid = rv;
    {rx_err, rx_char} = word; rd_en = re; lsr_rd = lr; tx_empty = te;
    cap  = m_deep ? 64 : 16;
    dchg = w && (cd[5] != m_deep);
    frx  = (w && cd[1]) || dchg;           // R12: clear wins
    ftx  = (w && cd[2]) || dchg;
    pop  = re && (mq.size() != 0) && !frx;
    push = rv && !frx && ((mq.size() < cap) || pop);   // R7
    drop = rv && !frx && (mq.size() == cap) && !pop;   // R6
    e_rdv = pop;
    if (pop) e_word = mq.pop_front();
    if (frx) mq.delete();
    if (push) mq.push_back(word);
    if (w) begin m_deep = cd[5]; m_dma = cd[3]; m_trig = cd[7:6]; end
    if (drop) m_ov = 1'b1; else if (lr) m_ov = 1'b0;
    e_irq = mq.size() >= thr_of(m_deep, m_trig);
    if (!m_dma) m_ready = mq.size() != 0;
    else if (mq.size() >= thr_of(m_deep, m_trig)) m_ready = 1'b1;
    else if (mq.size() == 0) m_ready = 1'b0;
    e_txr = te; e_txclr = ftx;
  endtask

  function automatic bit [10:0] rword();
    return 11'($urandom);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, rword(), 0, 0, 1);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R11: reset state
    cmp("R11 count", int'(count), 0);
    cmp("R11 data_irq", int'(data_irq), 0);
    cmp("R11 rx_ready", int'(rx_ready), 0);
    cmp("R11 overrun", int'(overrun), 0);
    cmp("R11 rd_valid", int'(rd_valid), 0);
    cmp("R11 tx_ready", int'(tx_ready), 0);
    cmp("R11 tx_clr", int'(tx_clr), 0);
    m_deep = 0; m_dma = 0; m_trig = 0; m_ov = 0; m_ready = 0;
    e_irq = 0; e_rdv = 0; e_txr = 0; e_txclr = 0; e_word = 0;

    // R12: read on empty queue
    step(0, 0, 0, 0, 1, 0, 1);
    // shallow fill past capacity: R6 drop, R5 thresholds
    fill(18);
    step(0, 0, 0, 0, 0, 1, 1);               // R6 line status read clears
    step(0, 0, 1, rword(), 1, 0, 1);         // R7 full plus read
    step(0, 0, 1, rword(), 0, 1, 1);         // R6 drop with lsr_rd: set wins
    // R3: fields change, bit 1 clear, contents kept
    step(1, 8'hC8, 0, 0, 0, 1, 0);
    drain(3);                                // R9 holds between levels
    step(1, 8'h48, 0, 0, 0, 0, 1);           // R3 again, trigger 1 mode 1
    drain(14);                               // R9 falls at empty
    fill(5);
    // R2 with R12: clear beats read and character in the same cycle
    step(1, 8'h02, 1, rword(), 1, 0, 1);
    step(1, 8'h00, 0, 0, 0, 0, 1);           // R2 bit not stored
    step(1, 8'h04, 0, 0, 0, 0, 0);           // R10 transmit clear pulse
    // R4: switch to 64 entries with trigger 3 mode 1, fill past capacity
    fill(3);
    step(1, 8'hE8, 0, 0, 0, 0, 1);
    fill(66);
    step(0, 0, 1, rword(), 1, 0, 1);         // R7 in deep setting
    drain(64);
    step(1, 8'h20 | 8'h40, 0, 0, 0, 1, 1);
    fill(20);
    step(1, 8'h00, 0, 0, 0, 0, 1);           // R4 back to 16: queue emptied
    idle(2);

    // random phases with different arrival/read mixes
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 4000; i++) begin
        bit       w;
        bit [7:0] cd;
        int       pw, pr;
        pw = (ph == 0) ? 85 : (ph == 1) ? 50 : (ph == 2) ? 25 : 70;
        pr = (ph == 0) ? 30 : (ph == 1) ? 50 : (ph == 2) ? 75 : 65;
        w  = ($urandom % 60) == 0;
        cd = 8'($urandom);
        if (($urandom % 4) != 0) cd[1] = 1'b0;
        if (($urandom % 4) != 0) cd[5] = m_deep;
        step(w, cd, ($urandom % 100) < pw, rword(), ($urandom % 100) < pr,
             ($urandom % 12) == 0, 1'($urandom));
      end
    end
    step(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule